// File: doc/BRIEF.md
# Cascadable Serial Gauge Command Interface

This block is the digital front end of a single air-core gauge driver. A host writes a 10-bit pointer position over a three-wire serial link: a select line that must be high for shifting, a shift clock, and a data line. The three pins are brought into the system clock domain through two-flop synchronisers. Edges are detected on the synchronised copies. A falling edge of the select line commits the received word to a holding register, and a one-cycle update strobe marks the commit. The analog coil stages downstream read that register.

A serial output runs in step with the input. On each falling shift-clock edge it presents the most significant bit of the shift register. During a frame it therefore streams out the word that was held before, so several drivers can share one port in a daisy chain. The output drive is gated by an enable input and by a short-circuit fault latch. A `short_det` input stands in for the analog short detector. The fault latch is cleared on each select falling edge. If the short is still present, the latch trips again on the next cycle. A status output, meant to steer an open-drain pull-down, is active whenever the outputs are off.

The system clock must run at no less than eight times the fastest shift clock. Each shift-clock phase must last at least three system clocks.

Top module: `gauge_serial_if`

## Requirements
- R1: While `csel` is high, each rising edge of `sclk` shifts `sdi` into the 10-bit shift register, most significant bit first. After ten such edges and a commit, `pos_word` equals the ten bits in the order sent.
- R2: Rising `sclk` edges that occur while `csel` is low leave the shift register unchanged. A later commit with no clocks in between still delivers the previously shifted word.
- R3: `pos_word` changes only at a commit. It stays at its old value during a whole frame of shifting and up to the commit.
- R4: A falling edge of `csel` loads `pos_word` with the shift register and raises `pos_update` for exactly one clock. Both appear on the third rising `clk` edge after the pin falls.
- R5: `sdo` changes only after a falling `sclk` edge, and then takes the shift register's most significant bit. Sampled before each rising `sclk` edge of a frame, it reproduces the previously shifted word MSB first. The first frame after reset reads zero.
- R6: `outputs_active` is high exactly when `out_en` is high and the fault latch is clear. `stat_pull_low` is its complement.
- R7: `short_det` high sets the fault latch on the next clock, which drops `outputs_active`. The latch stays set after `short_det` returns low.
- R8: The `clk` edge that commits a word also clears the fault latch. If `short_det` is still high, the latch sets again one clock later.
- R9: With `out_en` low, shifting, commits and `sdo` behave exactly as with `out_en` high.
- R10: A synchronous reset (`rst_n` low) clears the shift register, `pos_word`, `pos_update`, `sdo` and the fault latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the shift clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| sclk | input | 1 | Serial shift clock pin (asynchronous) |
| sdi | input | 1 | Serial data input pin (asynchronous) |
| csel | input | 1 | Select pin: high enables shifting, falling edge commits |
| out_en | input | 1 | Output enable, synchronous to clk |
| short_det | input | 1 | Short-circuit detector, synchronous to clk |
| sdo | output | 1 | Daisy-chain serial output |
| pos_word | output | 10 | Committed gauge position word |
| pos_update | output | 1 | One-cycle strobe on each commit |
| outputs_active | output | 1 | High when the coil outputs may drive |
| stat_pull_low | output | 1 | Status pull-down request, high while outputs are off |

## Verification
A pin change passes through two synchroniser flops and an edge detector before it acts. The shift register, `sdo`, `pos_word` and `pos_update` therefore update on the third rising `clk` edge after the pin moves. The bench drives its pins at falling `clk` edges. It reads commit results exactly two and three falling edges after dropping `csel`, and reads `sdo` four edges into each low shift-clock phase. The fault latch reacts to `short_det` and to a commit on the next edge, so its checks sample one falling edge after the cause. These checks look for the re-trip in the cycle that follows the clearing commit.

// File: rtl/gsi_pkg.sv
// Shared constants and types for the serial gauge command interface.
// Assumes a single system clock domain; the serial pins are asynchronous.
package gsi_pkg;
    // Width of one gauge position word.
    localparam int unsigned WORD_W     = 10;
    // Flops in each pin synchroniser.
    localparam int unsigned SYNC_DEPTH = 2;
    // Pins carried through the common synchroniser.
    localparam int unsigned NUM_PINS   = 3;
    localparam int unsigned PIN_SCLK   = 0;
    localparam int unsigned PIN_SDI    = 1;
    localparam int unsigned PIN_CSEL   = 2;

    // Which transition an edge detector reports.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;
endpackage

// File: rtl/gsi_sync.sv
// Multi-bit pin synchroniser: DEPTH flops per bit, reset to zero.
// Assumes each bit is independent (no bus coherency is required or given).
module gsi_sync #(
    parameter int unsigned WIDTH = 3,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] stage [DEPTH];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= pin_async;
    end

    // Remaining stages form the settling chain.
    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
        end
    end

    assign pin_sync = stage[DEPTH-1];
endmodule

// File: rtl/gsi_edge.sv
// Single-edge detector on an already synchronised signal.
// KIND picks a rising or falling detector; the event is high for one clk.
module gsi_edge #(
    parameter gsi_pkg::edge_kind_e KIND = gsi_pkg::EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic event_o
);
    logic prev_q;

    // Remember last cycle's level of the signal.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    if (KIND == gsi_pkg::EDGE_RISE) begin : g_rise
        assign event_o = sig & ~prev_q;
    end else begin : g_fall
        assign event_o = ~sig & prev_q;
    end
endmodule

// File: rtl/gsi_shift.sv
// Serial-in shift register with a registered daisy-chain output.
// Assumes shift_en and out_step are single-cycle events from edge detectors.
module gsi_shift #(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    input  logic              out_step,
    output logic [WORD_W-1:0] word,
    output logic              dout
);
    logic [WORD_W-1:0] sreg_q;
    logic              dout_q;

    // Shift new data in at the LSB end, MSB leaves first.
    always_ff @(posedge clk) begin
        if (!rst_n)        sreg_q <= '0;
        else if (shift_en) sreg_q <= {sreg_q[WORD_W-2:0], din};
    end

    // Present the current MSB on the chain output at each output step.
    always_ff @(posedge clk) begin
        if (!rst_n)        dout_q <= 1'b0;
        else if (out_step) dout_q <= sreg_q[WORD_W-1];
    end

    assign word = sreg_q;
    assign dout = dout_q;
endmodule

// File: rtl/gsi_fault_gate.sv
// Short-circuit fault latch and output gating.
// Assumes short_det and out_en are synchronous to clk. A clear request wins
// over a set in the same cycle, so a persisting short re-trips one clk later.
module gsi_fault_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic short_det,
    input  logic clear_req,
    input  logic out_en,
    output logic outputs_active,
    output logic stat_pull_low
);
    logic fault_q;

    // Latch a short; release it only on a clear request.
    always_ff @(posedge clk) begin
        if (!rst_n)         fault_q <= 1'b0;
        else if (clear_req) fault_q <= 1'b0;
        else if (short_det) fault_q <= 1'b1;
    end

    // Outputs drive only when enabled and no fault is held.
    always_comb begin
        outputs_active = out_en & ~fault_q;
        stat_pull_low  = ~outputs_active;
    end
endmodule

// File: rtl/gauge_serial_if.sv
// Top level of the cascadable serial gauge command interface.
// Synchronises the three serial pins, shifts words in while the select is
// high, commits on the select falling edge and gates the output drive.
// Assumes clk is at least 8x the shift clock rate.
module gauge_serial_if #(
    parameter int unsigned WORD_W     = gsi_pkg::WORD_W,
    parameter int unsigned SYNC_DEPTH = gsi_pkg::SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              csel,
    input  logic              out_en,
    input  logic              short_det,
    output logic              sdo,
    output logic [WORD_W-1:0] pos_word,
    output logic              pos_update,
    output logic              outputs_active,
    output logic              stat_pull_low
);
    import gsi_pkg::*;

    logic [NUM_PINS-1:0] pins_raw;
    logic [NUM_PINS-1:0] pins_s;
    logic                sclk_rise;
    logic                sclk_fall;
    logic                cs_fall;
    logic                shift_go;
    logic [WORD_W-1:0]   shift_word;
    logic [WORD_W-1:0]   hold_q;
    logic                upd_q;

    // Gather the pins in package index order.
    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_SCLK] = sclk;
        pins_raw[PIN_SDI]  = sdi;
        pins_raw[PIN_CSEL] = csel;
    end

    gsi_sync #(
        .WIDTH (NUM_PINS),
        .DEPTH (SYNC_DEPTH)
    ) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pins_raw),
        .pin_sync  (pins_s)
    );

    gsi_edge #(.KIND(EDGE_RISE)) i_sclk_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     (pins_s[PIN_SCLK]),
        .event_o (sclk_rise)
    );

    gsi_edge #(.KIND(EDGE_FALL)) i_sclk_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     (pins_s[PIN_SCLK]),
        .event_o (sclk_fall)
    );

    gsi_edge #(.KIND(EDGE_FALL)) i_cs_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     (pins_s[PIN_CSEL]),
        .event_o (cs_fall)
    );

    // Shift only on a clock rise seen while the select is high.
    assign shift_go = sclk_rise & pins_s[PIN_CSEL];

    gsi_shift #(.WORD_W(WORD_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_go),
        .din      (pins_s[PIN_SDI]),
        .out_step (sclk_fall),
        .word     (shift_word),
        .dout     (sdo)
    );

    // Commit the shifted word on a select falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (cs_fall) hold_q <= shift_word;
    end

    // One-cycle strobe that accompanies each commit.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= cs_fall;
    end

    gsi_fault_gate i_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .short_det      (short_det),
        .clear_req      (cs_fall),
        .out_en         (out_en),
        .outputs_active (outputs_active),
        .stat_pull_low  (stat_pull_low)
    );

    assign pos_word   = hold_q;
    assign pos_update = upd_q;
endmodule

// File: rtl/gauge_serial_if_chk.sv
// Assertion checker for gauge_serial_if, attached by bind below.
module gauge_serial_if_chk #(
    parameter int unsigned WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_fall,
    input logic              cs_fall,
    input logic              out_en,
    input logic              short_det,
    input logic              sdo,
    input logic [WORD_W-1:0] pos_word,
    input logic              pos_update,
    input logic              outputs_active,
    input logic              stat_pull_low
);
    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_word != $past(pos_word)) |-> pos_update);

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_update |=> !pos_update);

    // R5
    sdo_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(sclk_fall));

    // R6
    status_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> stat_pull_low);

    // R7
    short_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_det && !cs_fall) |=> !outputs_active);

    // R8
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_fall) && out_en) |-> outputs_active);

    // R10
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (pos_word == '0 && !pos_update && !sdo));
endmodule

bind gauge_serial_if gauge_serial_if_chk #(.WORD_W(WORD_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sclk_fall      (sclk_fall),
    .cs_fall        (cs_fall),
    .out_en         (out_en),
    .short_det      (short_det),
    .sdo            (sdo),
    .pos_word       (pos_word),
    .pos_update     (pos_update),
    .outputs_active (outputs_active),
    .stat_pull_low  (stat_pull_low)
);

// File: tb/test_gauge_serial_if.sv
// Bench: sweeps every 10-bit word through shift, commit and the chain output,
// then exercises the select-low case, the fault latch and the status gating.
module test_gauge_serial_if;
    localparam int W    = 10;
    localparam int HALF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic         csel = 1'b0;
    logic         out_en = 1'b1;
    logic         short_det = 1'b0;
    logic         sdo;
    logic [W-1:0] pos_word;
    logic         pos_update;
    logic         outputs_active;
    logic         stat_pull_low;

    int vectors = 0;
    int misses  = 0;

    always #2.5 clk = ~clk;

    gauge_serial_if i_gauge_serial_if (
        .clk            (clk),
        .rst_n          (rst_n),
        .sclk           (sclk),
        .sdi            (sdi),
        .csel           (csel),
        .out_en         (out_en),
        .short_det      (short_det),
        .sdo            (sdo),
        .pos_word       (pos_word),
        .pos_update     (pos_update),
        .outputs_active (outputs_active),
        .stat_pull_low  (stat_pull_low)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    // Shift one frame MSB first, collecting sdo before each rising clock.
    task automatic send_word(input logic [W-1:0] w, output logic [W-1:0] got);
        csel = 1'b1;
        hold(HALF);
        for (int b = W - 1; b >= 0; b--) begin
            sdi  = w[b];
            sclk = 1'b0;
            hold(HALF);
            got[b] = sdo;
            sclk = 1'b1;
            hold(HALF);
        end
        sclk = 1'b0;
        hold(HALF);
    endtask

    // Drop the select and check the commit timing.
    task automatic commit(input logic [W-1:0] old_w, input logic [W-1:0] new_w);
        csel = 1'b0;
        hold(2);
        chk("R4 word before commit edge", int'(pos_word), int'(old_w));
        chk("R4 strobe before commit edge", int'(pos_update), 0);
        hold(1);
        chk("R4 committed word", int'(pos_word), int'(new_w));
        chk("R4 strobe high", int'(pos_update), 1);
        hold(1);
        chk("R4 strobe one cycle", int'(pos_update), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 190000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [W-1:0] prev;
        logic [W-1:0] got;
        prev = '0;

        hold(3);
        rst_n = 1'b1;
        hold(1);
        // R10 reset state
        chk("R10 pos_word zero", int'(pos_word), 0);
        chk("R10 strobe low", int'(pos_update), 0);
        chk("R10 sdo low", int'(sdo), 0);
        chk("R6 active after reset", int'(outputs_active), 1);
        chk("R6 status after reset", int'(stat_pull_low), 0);

        // R1 R3 R5 R9 sweep every word
        for (int v = 0; v < (1 << W); v++) begin
            out_en = (v % 3 != 0);
            send_word(W'(v), got);
            chk("R5 chain output", int'(got), int'(prev));
            chk("R3 word held during frame", int'(pos_word), int'(prev));
            chk("R6 R9 active follows enable", int'(outputs_active), int'(out_en));
            commit(prev, W'(v));
            prev = W'(v);
        end
        out_en = 1'b1;

        // R2 clocks with select low are ignored
        send_word(10'h2A5, got);
        commit(prev, 10'h2A5);
        sdi = 1'b1;
        for (int b = 0; b < W; b++) begin
            sclk = 1'b1; hold(HALF);
            sclk = 1'b0; hold(HALF);
        end
        csel = 1'b1;
        hold(HALF);
        csel = 1'b0;
        hold(3);
        chk("R2 word after select-low clocks", int'(pos_word), 'h2A5);
        hold(2);

        // R7 short sets the latch, which persists
        short_det = 1'b1;
        hold(1);
        chk("R7 active drops", int'(outputs_active), 0);
        chk("R7 status asserted", int'(stat_pull_low), 1);
        short_det = 1'b0;
        hold(3);
        chk("R7 latch persists", int'(outputs_active), 0);

        // R8 commit clears the latch
        csel = 1'b1; hold(HALF);
        csel = 1'b0;
        hold(3);
        chk("R8 cleared by commit", int'(outputs_active), 1);
        hold(1);
        chk("R8 stays clear", int'(outputs_active), 1);

        // R8 re-trip when short persists
        short_det = 1'b1;
        hold(1);
        csel = 1'b1; hold(HALF);
        csel = 1'b0;
        hold(2);
        chk("R8 still faulted before commit", int'(outputs_active), 0);
        hold(1);
        chk("R8 briefly cleared", int'(outputs_active), 1);
        hold(1);
        chk("R8 re-trips", int'(outputs_active), 0);
        short_det = 1'b0;
        hold(2);

        // R6 enable and fault combinations
        out_en = 1'b1; hold(1);
        chk("R6 fault, enabled", int'(outputs_active), 0);
        out_en = 1'b0; hold(1);
        chk("R6 fault, disabled status", int'(stat_pull_low), 1);
        csel = 1'b1; hold(HALF);
        csel = 1'b0; hold(4);
        chk("R6 no fault, disabled", int'(outputs_active), 0);
        chk("R6 no fault, disabled status", int'(stat_pull_low), 1);
        out_en = 1'b1; hold(1);
        chk("R6 no fault, enabled", int'(outputs_active), 1);
        chk("R6 no fault, enabled status", int'(stat_pull_low), 0);

        // R10 reset mid-operation
        rst_n = 1'b0;
        hold(2);
        rst_n = 1'b1;
        hold(1);
        chk("R10 word cleared", int'(pos_word), 0);
        chk("R10 sdo cleared", int'(sdo), 0);

        summary();
        $finish;
    end
endmodule